// File: doc/BRIEF.md
# Two-Line Interrupt Summary Aggregator

This block gathers interrupt requests from up to eight secondary interrupt modules and turns them into one summary byte for each of two host interrupt lines. Bit n of a summary byte belongs to module n. Each host line has its own active-low interrupt output, asserted while that line's summary is nonzero. Hosts poll the summary bytes through a small byte-wide register port to find which module needs service.

Some modules can drive only one request output. For those, the line-1 request is copied into both lines' summaries, and their line-2 input is not used. A test register lets software force summary bits on both lines so that interrupt paths can be exercised without a real module event. Summary bits follow the request inputs level for level. Forced bits stay set until software writes the test register again.

Top module: `pih_aggregator`

## Requirements
- R1: Register address 0x01 reads the line-1 summary. For every populated module n (n < NUM_MODS), bit n equals req_l1[n], ORed with test bit n.
- R2: Register address 0x02 reads the line-2 summary. It is built from req_l2 the same way and is independent of req_l1 for modules that have two request outputs.
- R3: Summary and test-register bits at positions NUM_MODS and above always read 0, whatever the requests or written data.
- R4: For a module whose bit is set in SINGLE_MASK, req_l1[n] drives bit n of both summaries and req_l2[n] has no effect.
- R5: A write to address 0x03 loads the test register, masked to populated modules. Its value reads back at 0x03, and each set bit forces the matching bit in both summaries.
- R6: A request bit drops out of the summary as soon as its input returns to 0. A forced bit stays set until 0x03 is written with that bit cleared.
- R7: irq1_n (irq2_n) is low exactly when the line-1 (line-2) summary was nonzero at the previous rising clock edge.
- R8: A read of any address other than 0x01 to 0x03 returns 0. Writes to 0x01, 0x02 and unimplemented addresses change no state.
- R9: During and right after synchronous reset, the test register is 0, both interrupt outputs are high and reg_rdata is 0.
- R10: reg_rdata is updated on the rising edge where reg_rd is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_l1 | input | 8 | Module requests aimed at line 1, bit n from module n |
| req_l2 | input | 8 | Module requests aimed at line 2, bit n from module n |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq1_n | output | 1 | Line-1 interrupt, active low |
| irq2_n | output | 1 | Line-2 interrupt, active low |

## Verification
The bench applies all 256 line-1 request patterns, each paired with a different line-2 pattern, and repeats the sweep with the test register holding several values. This catches a design that swaps the lines, lets an unpopulated bit through, or fails to mirror the single-output module: such a design would show a wrong bit in one of the two summary reads or a wrong interrupt level. Forced bits are checked to survive the removal of all requests and to clear only when zero is written; a design that latched requests, or cleared forced bits on read, would return stale or missing bits. Writes to the status addresses and to unused addresses are followed by reads, so a design that decoded those writes would show a changed value.

// File: rtl/pih_pkg.sv
// Shared constants for the interrupt summary aggregator.
package pih_pkg;
    localparam int MAX_MODS = 8;
    localparam int ADDR_W   = 8;
    localparam logic [ADDR_W-1:0] ADDR_SUM1  = 8'h01;
    localparam logic [ADDR_W-1:0] ADDR_SUM2  = 8'h02;
    localparam logic [ADDR_W-1:0] ADDR_FORCE = 8'h03;

    // Mask with one bit set for each populated module.
    function automatic logic [MAX_MODS-1:0] pop_mask(input int n);
        logic [MAX_MODS-1:0] m;
        m = '0;
        for (int i = 0; i < MAX_MODS; i++)
            if (i < n) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/pih_force_reg.sv
// Test register that forces summary bits.
// Assumes the write is one cycle wide. Writes are masked to populated modules.
module pih_force_reg
    import pih_pkg::*;
#(
    parameter logic [MAX_MODS-1:0] POP = 8'hFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [MAX_MODS-1:0] wdata,
    output logic [MAX_MODS-1:0] force_bits
);
    // Hold forced bits until the next write to the test address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            force_bits <= '0;
        else if (wr_en)
            force_bits <= wdata & POP;
    end
endmodule

// File: rtl/pih_line_summary.sv
// Summary for one host line. Builds a level-driven summary from the requests
// and the forced bits, then registers the active-low interrupt.
// Line 0 uses its own requests. Line 1 takes the line-0 request for modules
// that have only one request output.
module pih_line_summary
    import pih_pkg::*;
#(
    parameter int                  LINE   = 0,
    parameter logic [MAX_MODS-1:0] POP    = 8'hFF,
    parameter logic [MAX_MODS-1:0] SINGLE = 8'h00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MAX_MODS-1:0] req_own,
    input  logic [MAX_MODS-1:0] req_first,
    input  logic [MAX_MODS-1:0] force_bits,
    output logic [MAX_MODS-1:0] summary,
    output logic                irq_n
);
    logic [MAX_MODS-1:0] merged;

    // Choose the request source for this line.
    generate
        if (LINE == 0) begin : g_first
            always_comb merged = req_own;
        end else begin : g_second
            always_comb merged = (req_own & ~SINGLE) | (req_first & SINGLE);
        end
    endgenerate

    // Level-driven summary, limited to populated modules.
    always_comb summary = (merged | force_bits) & POP;

    // Registered active-low interrupt for this line.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else
            irq_n <= ~(|summary);
    end
endmodule

// File: rtl/pih_read_mux.sv
// Registered read port. Decodes the address and returns zero for unused
// addresses. Holds the last value when no read is strobed.
module pih_read_mux
    import pih_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [MAX_MODS-1:0] sum1,
    input  logic [MAX_MODS-1:0] sum2,
    input  logic [MAX_MODS-1:0] force_bits,
    output logic [MAX_MODS-1:0] rdata
);
    logic [MAX_MODS-1:0] sel;

    // Address decode.
    always_comb begin
        case (addr)
            ADDR_SUM1:  sel = sum1;
            ADDR_SUM2:  sel = sum2;
            ADDR_FORCE: sel = force_bits;
            default:    sel = '0;
        endcase
    end

    // Capture read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= sel;
    end
endmodule

// File: rtl/pih_aggregator.sv
// Top level: two line summaries, a force register and the read port.
// NUM_MODS is the populated module count (1..8). SINGLE_MASK marks modules
// with one request output, whose line-1 request appears on both lines.
module pih_aggregator
    import pih_pkg::*;
#(
    parameter int                  NUM_MODS    = 7,
    parameter logic [MAX_MODS-1:0] SINGLE_MASK = 8'h40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MAX_MODS-1:0] req_l1,
    input  logic [MAX_MODS-1:0] req_l2,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [MAX_MODS-1:0] reg_wdata,
    input  logic                reg_rd,
    output logic [MAX_MODS-1:0] reg_rdata,
    output logic                irq1_n,
    output logic                irq2_n
);
    localparam logic [MAX_MODS-1:0] POP = pop_mask(NUM_MODS);
    localparam int NUM_LINES = 2;

    logic [MAX_MODS-1:0] force_bits;
    logic                force_wr;
    logic [MAX_MODS-1:0] req_arr [NUM_LINES];
    logic [MAX_MODS-1:0] sum_arr [NUM_LINES];
    logic                irq_arr [NUM_LINES];
    logic [MAX_MODS-1:0] sum1, sum2;

    // Only the test address accepts writes.
    always_comb force_wr = reg_wr && (reg_addr == ADDR_FORCE);

    // Gather per-line inputs and outputs.
    always_comb begin
        req_arr[0] = req_l1;
        req_arr[1] = req_l2;
        sum1       = sum_arr[0];
        sum2       = sum_arr[1];
        irq1_n     = irq_arr[0];
        irq2_n     = irq_arr[1];
    end

    pih_force_reg #(.POP(POP)) u_force (
        .clk(clk), .rst_n(rst_n), .wr_en(force_wr),
        .wdata(reg_wdata), .force_bits(force_bits)
    );

    genvar ln;
    generate
        for (ln = 0; ln < NUM_LINES; ln++) begin : g_line
            pih_line_summary #(.LINE(ln), .POP(POP), .SINGLE(SINGLE_MASK)) u_line (
                .clk(clk), .rst_n(rst_n), .req_own(req_arr[ln]),
                .req_first(req_l1), .force_bits(force_bits),
                .summary(sum_arr[ln]), .irq_n(irq_arr[ln])
            );
        end
    endgenerate

    pih_read_mux u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(reg_rd), .addr(reg_addr),
        .sum1(sum1), .sum2(sum2), .force_bits(force_bits), .rdata(reg_rdata)
    );
endmodule

// File: rtl/pih_aggregator_chk.sv
// Property checker for the aggregator, bound into every instance.
module pih_aggregator_chk
    import pih_pkg::*;
#(
    parameter logic [MAX_MODS-1:0] POP    = 8'hFF,
    parameter logic [MAX_MODS-1:0] SINGLE = 8'h00
) (
    input logic                clk,
    input logic                rst_n,
    input logic [MAX_MODS-1:0] sum1,
    input logic [MAX_MODS-1:0] sum2,
    input logic [MAX_MODS-1:0] force_bits,
    input logic                irq1_n,
    input logic                irq2_n,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr,
    input logic                reg_rd,
    input logic [MAX_MODS-1:0] reg_rdata
);
    a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum1 | sum2 | force_bits) & ~POP) == '0);

    a_r4_single_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum1 ^ sum2) & SINGLE & POP) == '0);

    a_r5_force_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ((force_bits & ~sum1) | (force_bits & ~sum2)) == '0);

    a_r6_force_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_FORCE) |=> $stable(force_bits));

    a_r7_irq1_level: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq1_n == ($past(sum1) == '0)));

    a_r7_irq2_level: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq2_n == ($past(sum2) == '0)));

    a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == 8'h00 || reg_addr > ADDR_FORCE)) |=> reg_rdata == '0);

    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind pih_aggregator pih_aggregator_chk #(.POP(POP), .SINGLE(SINGLE_MASK)) u_chk (
    .clk(clk), .rst_n(rst_n), .sum1(sum1), .sum2(sum2), .force_bits(force_bits),
    .irq1_n(irq1_n), .irq2_n(irq2_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
);

// File: tb/test_pih_aggregator.sv
`timescale 1ns/1ps
// Bench: sweeps all request patterns under several forced values.
module test_pih_aggregator;
    localparam int NMOD = 7;
    localparam logic [7:0] POPM = 8'h7F;
    localparam logic [7:0] SGL  = 8'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] req_l1 = '0, req_l2 = '0, reg_addr = '0, reg_wdata = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic irq1_n, irq2_n;
    int total = 0, bad = 0;
    logic [7:0] frc = '0;
    logic [7:0] got;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pih_aggregator #(.NUM_MODS(NMOD), .SINGLE_MASK(SGL)) i_pih_aggregator (
        .clk(clk), .rst_n(rst_n), .req_l1(req_l1), .req_l2(req_l2),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq1_n(irq1_n), .irq2_n(irq2_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Drive at negedge, sample at the following negedge.
    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] exp1(input logic [7:0] r1, input logic [7:0] f);
        return (r1 | f) & POPM;
    endfunction
    function automatic logic [7:0] exp2(input logic [7:0] r1, input logic [7:0] r2,
                                        input logic [7:0] f);
        return (((r2 & ~SGL) | (r1 & SGL)) | f) & POPM;
    endfunction

    task automatic sweep(input logic [7:0] f);
        for (int v = 0; v < 256; v++) begin
            logic [7:0] e1, e2;
            req_l1 = 8'(v);
            req_l2 = 8'(v) ^ 8'hA5 ^ 8'(v << 3);
            e1 = exp1(req_l1, f);
            e2 = exp2(req_l1, req_l2, f);
            rd(8'h01, got);
            check("R1 line1 summary", got, e1);
            check("R7 irq1_n", {7'd0, irq1_n}, {7'd0, e1 == 8'd0});
            check("R7 irq2_n", {7'd0, irq2_n}, {7'd0, e2 == 8'd0});
            rd(8'h02, got);
            check("R2 R4 line2 summary", got, e2);
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        req_l1 = 8'hFF; req_l2 = 8'hFF;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 irq1_n in reset", {7'd0, irq1_n}, 8'd1);
        check("R9 irq2_n in reset", {7'd0, irq2_n}, 8'd1);
        check("R9 rdata in reset", reg_rdata, 8'd0);
        rst_n = 1'b1;
        req_l1 = '0; req_l2 = '0;
        @(negedge clk);
        rd(8'h03, got);
        check("R9 force clear after reset", got, 8'd0);
        check("R9 irq1_n idle", {7'd0, irq1_n}, 8'd1);

        sweep(8'h00);
        wr(8'h03, 8'h15); frc = 8'h15;
        rd(8'h03, got);
        check("R5 force readback", got, frc);
        sweep(frc);
        // R3: upper bit masked on write
        wr(8'h03, 8'hFF); frc = 8'h7F;
        rd(8'h03, got);
        check("R3 force masked", got, frc);
        sweep(frc);

        // R6: force persists with no requests; request bit drops at once
        wr(8'h03, 8'h08); frc = 8'h08;
        req_l1 = 8'h01; req_l2 = 8'h00;
        rd(8'h01, got);
        check("R6 request plus force", got, 8'h09);
        req_l1 = 8'h00;
        rd(8'h01, got);
        check("R6 request drops force stays", got, 8'h08);
        rd(8'h02, got);
        check("R6 force on line2", got, 8'h08);
        check("R6 irq2_n held by force", {7'd0, irq2_n}, 8'd0);
        wr(8'h03, 8'h00); frc = 8'h00;
        rd(8'h01, got);
        check("R6 force cleared by zero write", got, 8'h00);
        @(negedge clk);
        check("R6 irq1_n released", {7'd0, irq1_n}, 8'd1);

        // R8: writes to status and unused addresses ignored
        req_l1 = 8'h02; req_l2 = 8'h04;
        wr(8'h01, 8'hFF);
        wr(8'h02, 8'hFF);
        wr(8'h07, 8'hFF);
        rd(8'h01, got); check("R8 write 0x01 ignored", got, 8'h02);
        rd(8'h02, got); check("R8 write 0x02 ignored", got, 8'h04);
        rd(8'h03, got); check("R8 unused write leaves force", got, 8'h00);
        foreach (got[i]) ; // no-op keeps loop style simple
        for (int a = 0; a < 256; a++) begin
            if (a >= 1 && a <= 3) continue;
            rd(8'(a), got);
            check("R8 unused address reads zero", got, 8'h00);
        end

        // R10: rdata holds without a read strobe
        rd(8'h01, got);
        req_l1 = 8'h10;
        @(negedge clk); @(negedge clk);
        check("R10 rdata holds", reg_rdata, 8'h02);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule